// File: doc/BRIEF.md
# Bufferless Two-by-Two Slotted Switch Node Controller

This block is the control of a single two-input, two-output element in a slotted multistage fabric that holds no messages in storage. Each input carries a presence bit and the one routing bit this stage uses. At the start of every slot the node samples both headers, picks one connection pattern and keeps it until the slot is closed. If both messages want the same output, one of them is discarded. The policy that picks the survivor can be set to fixed priority, alternation or pseudo-random choice.

The established connections carry a single-bit data lane and a payload tag forward. They carry a one-bit acknowledgment backward, from each output to the input it is connected to, so the sender learns within the slot whether its message got through. A configurable guard interval after the decision has to pass before the forwarded payload is flagged valid. The node sends no information to its neighbours and adds nothing to a message.

Top module: `node_switch`

## Requirements
- R1: While reset is held and after it is released, `nodeState` is 0 (idle), and `outLive`, `outValid` and `ackOut` are all zero.
- R2: Headers are taken only in a cycle where `slotStart` is high. The new state shows one clock later. A route bit of 0 asks for the upper output (index 0) and 1 asks for the lower output (index 1). An input whose frame bit is 0 is absent, so with no frame present the state is 0 and no output is live.
- R3: With only one input present, the state is 3 (upper input to upper output), 4 (upper input to lower output), 5 (lower input to lower output) or 6 (lower input to upper output). Exactly the requested output becomes live.
- R4: With both inputs present and asking for different outputs, the state is 1 (straight: upper to upper, lower to lower) or 2 (interchange). Both outputs are live.
- R5: On contention (both present, same route bit) with `policySel` 0 or 3, the upper input survives. The state is 3 or 4 according to its route bit.
- R6: With `policySel` 1 the survivor alternates between contentions, starting with the upper input after reset. A slot without contention does not advance the alternation.
- R7: With `policySel` 2 the survivor comes from an internal pseudo-random sequence. Exactly one output is live, and over repeated contentions each input survives at least once.
- R8: Once latched, the state ignores any change of frame or route bits until the next `slotStart` or `slotEnd`.
- R9: `slotEnd` returns the state to 0 one clock later. If `slotStart` and `slotEnd` are high together, the new slot's state is taken.
- R10: `outValid` for a live output goes high exactly GUARD_CYCLES clocks after the state was latched, and never earlier.
- R11: A live output carries the data bit and tag of its connected input. A dropped input's data and tag appear on no output, and a non-live output carries zero data and zero tag.
- R12: `ackOut` of an input equals `ackIn` of the output it is connected to. An input without a connection returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStart | input | 1 | Strobe: sample headers and latch the connection state |
| slotEnd | input | 1 | Strobe: release the connection state |
| policySel | input | 2 | Contention policy: 0/3 fixed, 1 alternating, 2 pseudo-random |
| inFrame | input | 2 | Presence bit of each input (index 0 = upper) |
| inRoute | input | 2 | This stage's routing bit of each input |
| inData | input | 2 | Forward data lane of each input |
| inTag | input | 2*TAG_W | Payload tag of each input |
| ackIn | input | 2 | Acknowledgment arriving at each output from downstream |
| outLive | output | 2 | Output currently connected to an input |
| outValid | output | 2 | Output live and guard interval elapsed |
| outData | output | 2 | Forward data lane of each output |
| outTag | output | 2*TAG_W | Payload tag of each output |
| ackOut | output | 2 | Acknowledgment returned toward each input |
| nodeState | output | 3 | Latched connection state code |

## Verification
The bench builds the node with GUARD_CYCLES set to 3 and TAG_W set to 8. It keeps the default 16-bit generator. A guard of three cycles lets the bench probe the cycle before and the cycle of the payload-valid edge in every slot, and 8-bit tags with distinct patterns per input make a swapped or leaked tag visible. The generator's low bit changes often enough that both survivors appear within a few dozen contentions, so the pseudo-random policy can be checked for its outcome as well as its legality.

// File: rtl/node_pkg.sv
package node_pkg;

  // Connection state codes; values are visible on the nodeState port.
  typedef enum logic [2:0] {
    RT_IDLE     = 3'd0,
    RT_STRAIGHT = 3'd1,
    RT_CROSS    = 3'd2,
    RT_UP_STR   = 3'd3,
    RT_UP_CRS   = 3'd4,
    RT_LO_STR   = 3'd5,
    RT_LO_CRS   = 3'd6
  } route_e;

  typedef enum logic [1:0] {
    POL_FIXED  = 2'd0,
    POL_ALT    = 2'd1,
    POL_RAND   = 2'd2,
    POL_FIXED2 = 2'd3
  } policy_e;

  // Strobes handed from control to datapath.
  typedef struct packed {
    route_e route;
    logic   payloadOk;
  } nodeCtl_t;

endpackage

// File: rtl/node_arb.sv
module node_arb
  import node_pkg::*;
#(
  parameter int unsigned LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       contend,
  input  logic [1:0] policySel,
  output logic       winLower
);

  logic              altBit;
  logic [LFSR_W-1:0] lfsr;

  // Free-running Galois generator; alternation flop moves only on contention.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      altBit <= 1'b0;
      lfsr   <= LFSR_SEED;
    end else begin
      lfsr <= lfsr[0] ? ((lfsr >> 1) ^ LFSR_TAPS) : (lfsr >> 1);
      if (contend && policySel == POL_ALT) altBit <= ~altBit;
    end
  end

  always_comb begin
    case (policySel)
      POL_ALT:  winLower = altBit;
      POL_RAND: winLower = lfsr[0];
      default:  winLower = 1'b0;
    endcase
  end

endmodule

// File: rtl/node_ctrl.sv
module node_ctrl
  import node_pkg::*;
#(
  parameter int unsigned GUARD_CYCLES = 4,
  parameter int unsigned LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotStart,
  input  logic       slotEnd,
  input  logic [1:0] policySel,
  input  logic [1:0] inFrame,
  input  logic [1:0] inRoute,
  output nodeCtl_t   ctl
);

  localparam int unsigned CNT_W = (GUARD_CYCLES > 0) ? $clog2(GUARD_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] GUARD_LD = CNT_W'(GUARD_CYCLES);

  route_e           route;
  route_e           nextRoute;
  logic [CNT_W-1:0] guardCnt;
  logic             contend;
  logic             winLower;

  assign contend = slotStart & inFrame[0] & inFrame[1] & (inRoute[0] == inRoute[1]);

  node_arb #(
    .LFSR_W   (LFSR_W),
    .LFSR_TAPS(LFSR_TAPS),
    .LFSR_SEED(LFSR_SEED)
  ) arb (
    .clk      (clk),
    .rstN     (rstN),
    .contend  (contend),
    .policySel(policySel),
    .winLower (winLower)
  );

  // Decision from the leading-edge headers.
  always_comb begin
    nextRoute = RT_IDLE;
    case (inFrame)
      2'b01: nextRoute = inRoute[0] ? RT_UP_CRS : RT_UP_STR;
      2'b10: nextRoute = inRoute[1] ? RT_LO_STR : RT_LO_CRS;
      2'b11: begin
        if (inRoute[0] != inRoute[1])
          nextRoute = inRoute[0] ? RT_CROSS : RT_STRAIGHT;
        else if (winLower)
          nextRoute = inRoute[1] ? RT_LO_STR : RT_LO_CRS;
        else
          nextRoute = inRoute[0] ? RT_UP_CRS : RT_UP_STR;
      end
      default: nextRoute = RT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      route    <= RT_IDLE;
      guardCnt <= '0;
    end else if (slotStart) begin
      route    <= nextRoute;
      guardCnt <= GUARD_LD;
    end else if (slotEnd) begin
      route    <= RT_IDLE;
      guardCnt <= '0;
    end else if (guardCnt != '0) begin
      guardCnt <= guardCnt - 1'b1;
    end
  end

  assign ctl.route     = route;
  assign ctl.payloadOk = (route != RT_IDLE) && (guardCnt == '0);

endmodule

// File: rtl/node_dpath.sv
module node_dpath
  import node_pkg::*;
#(
  parameter int unsigned TAG_W = 16
) (
  input  nodeCtl_t               ctl,
  input  logic [1:0]             inData,
  input  logic [1:0][TAG_W-1:0]  inTag,
  input  logic [1:0]             ackIn,
  output logic [1:0]             outLive,
  output logic [1:0]             outValid,
  output logic [1:0]             outData,
  output logic [1:0][TAG_W-1:0]  outTag,
  output logic [1:0]             ackOut
);

  logic [1:0] outEn;
  logic [1:0] outSrc;

  always_comb begin
    outEn  = 2'b00;
    outSrc = 2'b10;
    case (ctl.route)
      RT_STRAIGHT: begin outEn = 2'b11; outSrc = 2'b10; end
      RT_CROSS:    begin outEn = 2'b11; outSrc = 2'b01; end
      RT_UP_STR:   begin outEn = 2'b01; outSrc[0] = 1'b0; end
      RT_UP_CRS:   begin outEn = 2'b10; outSrc[1] = 1'b0; end
      RT_LO_STR:   begin outEn = 2'b10; outSrc[1] = 1'b1; end
      RT_LO_CRS:   begin outEn = 2'b01; outSrc[0] = 1'b1; end
      default:     begin outEn = 2'b00; end
    endcase
  end

  for (genvar o = 0; o < 2; o++) begin : g_out
    assign outData[o]  = outEn[o] & inData[outSrc[o]];
    assign outTag[o]   = outEn[o] ? inTag[outSrc[o]] : '0;
    assign outValid[o] = outEn[o] & ctl.payloadOk;
  end

  assign outLive = outEn;

  // Reverse lane follows the same connections backward.
  always_comb begin
    ackOut = 2'b00;
    for (int o = 0; o < 2; o++) begin
      if (outEn[o]) ackOut[outSrc[o]] = ackOut[outSrc[o]] | ackIn[o];
    end
  end

endmodule

// File: rtl/node_switch.sv
module node_switch
  import node_pkg::*;
#(
  parameter int unsigned GUARD_CYCLES = 4,
  parameter int unsigned TAG_W        = 16,
  parameter int unsigned LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotStart,
  input  logic                   slotEnd,
  input  logic [1:0]             policySel,
  input  logic [1:0]             inFrame,
  input  logic [1:0]             inRoute,
  input  logic [1:0]             inData,
  input  logic [1:0][TAG_W-1:0]  inTag,
  input  logic [1:0]             ackIn,
  output logic [1:0]             outLive,
  output logic [1:0]             outValid,
  output logic [1:0]             outData,
  output logic [1:0][TAG_W-1:0]  outTag,
  output logic [1:0]             ackOut,
  output logic [2:0]             nodeState
);

  nodeCtl_t ctl;

  node_ctrl #(
    .GUARD_CYCLES(GUARD_CYCLES),
    .LFSR_W      (LFSR_W),
    .LFSR_TAPS   (LFSR_TAPS),
    .LFSR_SEED   (LFSR_SEED)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotStart(slotStart),
    .slotEnd  (slotEnd),
    .policySel(policySel),
    .inFrame  (inFrame),
    .inRoute  (inRoute),
    .ctl      (ctl)
  );

  node_dpath #(
    .TAG_W(TAG_W)
  ) dpath (
    .ctl     (ctl),
    .inData  (inData),
    .inTag   (inTag),
    .ackIn   (ackIn),
    .outLive (outLive),
    .outValid(outValid),
    .outData (outData),
    .outTag  (outTag),
    .ackOut  (ackOut)
  );

  assign nodeState = ctl.route;

endmodule

// File: rtl/node_switch_chk.sv
module node_switch_chk #(
  parameter int unsigned GUARD_CYCLES = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       slotStart,
  input logic       slotEnd,
  input logic [1:0] policySel,
  input logic [1:0] inFrame,
  input logic [1:0] inRoute,
  input logic [1:0] ackIn,
  input logic [1:0] outLive,
  input logic [1:0] outValid,
  input logic [1:0] ackOut,
  input logic [2:0] nodeState
);

  logic        clash;
  logic [31:0] sinceStart;

  assign clash = inFrame[0] & inFrame[1] & (inRoute[0] == inRoute[1]);

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceStart <= '0;
    else if (slotStart)         sinceStart <= '0;
    else if (sinceStart != '1)  sinceStart <= sinceStart + 1'b1;
  end

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && inFrame == 2'b00) |=> (outLive == 2'b00 && nodeState == 3'd0));

  p_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && inFrame == 2'b11 && inRoute[0] != inRoute[1]) |=> (outLive == 2'b11));

  p_fixed_upper_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && clash && (policySel == 2'd0 || policySel == 2'd3))
      |=> (nodeState == 3'd3 || nodeState == 3'd4));

  p_single_winner_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && clash) |=> ($countones(outLive) == 1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!slotStart && !slotEnd) |=> $stable(nodeState));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (slotEnd && !slotStart) |=> (nodeState == 3'd0 && outLive == 2'b00 && ackOut == 2'b00));

  p_guard_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid != 2'b00) |-> (sinceStart >= 32'(GUARD_CYCLES)));

  p_ack_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut != 2'b00) |-> (ackIn != 2'b00 && outLive != 2'b00));

endmodule

bind node_switch node_switch_chk #(
  .GUARD_CYCLES(GUARD_CYCLES)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .slotStart(slotStart),
  .slotEnd  (slotEnd),
  .policySel(policySel),
  .inFrame  (inFrame),
  .inRoute  (inRoute),
  .ackIn    (ackIn),
  .outLive  (outLive),
  .outValid (outValid),
  .ackOut   (ackOut),
  .nodeState(nodeState)
);

// File: tb/node_switch_test.sv
module node_switch_test;

  localparam int unsigned GUARD = 3;
  localparam int unsigned TW    = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             slotStart, slotEnd;
  logic [1:0]       policySel, inFrame, inRoute, inData, ackIn;
  logic [1:0][TW-1:0] inTag;
  logic [1:0]       outLive, outValid, outData, ackOut;
  logic [1:0][TW-1:0] outTag;
  logic [2:0]       nodeState;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  node_switch #(.GUARD_CYCLES(GUARD), .TAG_W(TW)) uut (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .slotEnd(slotEnd),
    .policySel(policySel), .inFrame(inFrame), .inRoute(inRoute),
    .inData(inData), .inTag(inTag), .ackIn(ackIn),
    .outLive(outLive), .outValid(outValid), .outData(outData),
    .outTag(outTag), .ackOut(ackOut), .nodeState(nodeState)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startSlot(input logic [1:0] f, input logic [1:0] r, input logic [1:0] pol);
    @(negedge clk);
    inFrame = f; inRoute = r; policySel = pol; slotStart = 1'b1;
    @(negedge clk);
    slotStart = 1'b0;
  endtask

  task automatic endSlot();
    @(negedge clk);
    slotEnd = 1'b1;
    @(negedge clk);
    slotEnd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", 32'(nodeState), 0);
    chk("R1 live", 32'(outLive), 0);
    chk("R1 valid", 32'(outValid), 0);
    chk("R1 ack", 32'(ackOut), 0);
  endtask

  task automatic t_single();
    startSlot(2'b00, 2'b11, 2'd0);
    chk("R2 absent frames idle", 32'(nodeState), 0);
    chk("R2 absent frames no live", 32'(outLive), 0);
    endSlot();
    startSlot(2'b01, 2'b00, 2'd0);
    chk("R3 upper to upper", 32'(nodeState), 3);
    chk("R3 upper to upper live", 32'(outLive), 2'b01);
    endSlot();
    startSlot(2'b01, 2'b01, 2'd0);
    chk("R3 upper to lower", 32'(nodeState), 4);
    chk("R3 upper to lower live", 32'(outLive), 2'b10);
    endSlot();
    startSlot(2'b10, 2'b10, 2'd0);
    chk("R3 lower to lower", 32'(nodeState), 5);
    endSlot();
    startSlot(2'b10, 2'b00, 2'd0);
    chk("R3 lower to upper", 32'(nodeState), 6);
    chk("R3 lower to upper live", 32'(outLive), 2'b01);
    endSlot();
  endtask

  task automatic t_pair();
    inData = 2'b01; inTag[0] = 8'hA5; inTag[1] = 8'h3C;
    startSlot(2'b11, 2'b10, 2'd0);
    chk("R4 straight", 32'(nodeState), 1);
    chk("R4 straight live", 32'(outLive), 2'b11);
    chk("R11 straight data", 32'(outData), 2'b01);
    ackIn = 2'b10; #1;
    chk("R12 straight ack", 32'(ackOut), 2'b10);
    ackIn = 2'b00;
    endSlot();
    startSlot(2'b11, 2'b01, 2'd0);
    chk("R4 interchange", 32'(nodeState), 2);
    chk("R11 interchange data", 32'(outData), 2'b10);
    chk("R11 interchange tag0", 32'(outTag[0]), 8'h3C);
    chk("R11 interchange tag1", 32'(outTag[1]), 8'hA5);
    ackIn = 2'b01; #1;
    chk("R12 interchange ack", 32'(ackOut), 2'b10);
    ackIn = 2'b00;
    endSlot();
    startSlot(2'b01, 2'b01, 2'd0);
    ackIn = 2'b11; #1;
    chk("R12 unconnected input gets no ack", 32'(ackOut), 2'b01);
    ackIn = 2'b00;
    endSlot();
  endtask

  task automatic t_fixed();
    inData = 2'b11; inTag[0] = 8'h11; inTag[1] = 8'hEE;
    startSlot(2'b11, 2'b00, 2'd0);
    chk("R5 fixed upper wins", 32'(nodeState), 3);
    chk("R11 dropped data absent", 32'(outData), 2'b01);
    chk("R11 dropped tag absent", 32'(outTag[1]), 0);
    chk("R11 winner tag", 32'(outTag[0]), 8'h11);
    endSlot();
    startSlot(2'b11, 2'b11, 2'd0);
    chk("R5 fixed upper wins lower dest", 32'(nodeState), 4);
    endSlot();
    startSlot(2'b11, 2'b00, 2'd3);
    chk("R5 code 3 acts as fixed", 32'(nodeState), 3);
    endSlot();
  endtask

  task automatic t_alt();
    startSlot(2'b11, 2'b11, 2'd1);
    chk("R6 first contention upper", 32'(nodeState), 4);
    endSlot();
    startSlot(2'b01, 2'b00, 2'd1);
    chk("R6 no contention", 32'(nodeState), 3);
    endSlot();
    startSlot(2'b11, 2'b11, 2'd1);
    chk("R6 second contention lower", 32'(nodeState), 5);
    endSlot();
    startSlot(2'b11, 2'b11, 2'd1);
    chk("R6 third contention upper", 32'(nodeState), 4);
    endSlot();
  endtask

  task automatic t_hold();
    startSlot(2'b11, 2'b10, 2'd0);
    @(negedge clk);
    inFrame = 2'b01; inRoute = 2'b01;
    repeat (3) @(negedge clk);
    chk("R8 state held", 32'(nodeState), 1);
    chk("R8 live held", 32'(outLive), 2'b11);
    endSlot();
  endtask

  task automatic t_guard();
    startSlot(2'b10, 2'b10, 2'd0);
    chk("R10 not valid at latch", 32'(outValid), 0);
    @(negedge clk);
    chk("R10 not valid +1", 32'(outValid), 0);
    @(negedge clk);
    chk("R10 not valid +2", 32'(outValid), 0);
    @(negedge clk);
    chk("R10 valid at guard", 32'(outValid), 2'b10);
    endSlot();
    chk("R9 cleared", 32'(nodeState), 0);
    chk("R9 no valid", 32'(outValid), 0);
    startSlot(2'b01, 2'b00, 2'd0);
    @(negedge clk);
    inFrame = 2'b10; inRoute = 2'b10; slotStart = 1'b1; slotEnd = 1'b1;
    @(negedge clk);
    slotStart = 1'b0; slotEnd = 1'b0;
    chk("R9 start wins over end", 32'(nodeState), 5);
    endSlot();
  endtask

  task automatic t_random();
    int upWins = 0;
    int loWins = 0;
    for (int i = 0; i < 32; i++) begin
      startSlot(2'b11, 2'b00, 2'd2);
      chk("R7 one live", 32'($countones(outLive)), 1);
      if (nodeState == 3'd3) upWins++;
      else if (nodeState == 3'd6) loWins++;
      else chk("R7 legal state", 32'(nodeState), 3);
      endSlot();
      repeat (i % 3) @(negedge clk);
    end
    chk("R7 upper won sometimes", 32'(upWins > 0), 1);
    chk("R7 lower won sometimes", 32'(loWins > 0), 1);
  endtask

  initial begin
    rstN = 1'b0; slotStart = 1'b0; slotEnd = 1'b0; policySel = 2'd0;
    inFrame = 2'b00; inRoute = 2'b00; inData = 2'b00; ackIn = 2'b00;
    inTag = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_pair();
    t_fixed();
    t_alt();
    t_hold();
    t_guard();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule